// File: doc/BRIEF.md
# Saturating multiply-accumulate unit

This block holds a 64-bit accumulator, seen as a high and a low 32-bit half, and applies one arithmetic command to it per clock. The commands are multiply-accumulate in 16x16 and 32x32 signed forms, full 32x32 signed and unsigned products written over the whole accumulator, a 32-bit low-word product, 16x16 signed and unsigned products written into the low half, clear, and loads of either half. Operands are already fetched when the command is presented.

A saturation flag arrives with each command. When it is set, the two accumulate forms clamp in different ways. The 16x16 form limits only the low half to the signed 32-bit range and flags overflow by writing 1 to the high half. The 32x32 form clamps the whole sum to a signed 48-bit range. Both halves are always visible on output ports, so reading a half needs no command.

Top module: `mac_unit`

## Requirements
- R1: While reset is active and after it is released, both accumulator halves read zero and `done_o` is low.
- R2: A command is taken on each rising edge where `cmd_valid_i` is high. Its result appears on `acc_hi_o`/`acc_lo_o` after that edge, and `done_o` is high for exactly the following cycle. Codes on `cmd_op_i`: 0 clear, 1 16x16 MAC, 2 32x32 MAC, 3 signed full multiply, 4 unsigned full multiply, 5 low-word multiply, 6 signed 16x16 multiply, 7 unsigned 16x16 multiply, 8 load high half, 9 load low half. Any other code leaves the accumulator unchanged.
- R3: Clear (code 0) sets all 64 bits to zero.
- R4: Load high (code 8) writes `opa_i` into the high half and keeps the low half. Load low (code 9) writes `opa_i` into the low half and keeps the high half.
- R5: 16x16 MAC with `sat_i`=0 adds the signed product of the low 16 bits of each operand, sign-extended to 64 bits, to the full accumulator with wrap-around.
- R6: 16x16 MAC with `sat_i`=1 forms the signed low half plus the product. A sum above 0x7FFFFFFF gives an accumulator of 0x00000001_7FFFFFFF. A sum below -2^31 gives 0x00000001_80000000.
- R7: 16x16 MAC with `sat_i`=1 and a sum inside the signed 32-bit range, including both limits, writes the sum into the low half and leaves the high half unchanged.
- R8: 32x32 MAC with `sat_i`=0 adds the signed 64-bit product of the operands to the accumulator, modulo 2^64.
- R9: 32x32 MAC with `sat_i`=1 clamps the sum to 0xFFFF8000_00000000 .. 0x00007FFF_FFFFFFFF. A sum exactly at a limit is kept as it is.
- R10: The signed (code 3) and unsigned (code 4) full multiplies replace all 64 bits with the 64-bit product.
- R11: The low-word multiply (code 5) writes the low 32 bits of the product into the low half and keeps the high half.
- R12: The 16x16 multiplies write a 32-bit product into the low half and keep the high half. Code 6 sign-extends the low 16 bits of each operand; code 7 zero-extends them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Command code |
| sat_i | input | 1 | Saturation mode for this command |
| opa_i | input | 32 | First operand, also the load value |
| opb_i | input | 32 | Second operand |
| acc_hi_o | output | 32 | Accumulator high half |
| acc_lo_o | output | 32 | Accumulator low half |
| done_o | output | 1 | Result of the previous cycle's command is visible |

## Verification
Every command's result is due one clock after the edge that accepts it, and `done_o` marks that cycle. The driver computes the expected 64-bit value from the requirement rules when it issues a command and queues it. The monitor samples on the falling edge, and only in cycles where `done_o` is high, so it pops exactly one expected value per accepted command. It also flags a result that arrives with no queued command behind it.

Each saturation limit is approached from both sides: one sum lands exactly on the limit and one goes a single unit past it. This is done in both 16x16 and 32x32 form and in both modes. Random commands then run back to back.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_CLR    = 4'd0,
    OP_MAC16  = 4'd1,
    OP_MAC32  = 4'd2,
    OP_MULS64 = 4'd3,
    OP_MULU64 = 4'd4,
    OP_MUL32  = 4'd5,
    OP_MULS16 = 4'd6,
    OP_MULU16 = 4'd7,
    OP_LDHI   = 4'd8,
    OP_LDLO   = 4'd9
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int W = 32,
  parameter int H = 16
) (
  input  mac_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int DW = 2 * W;

  logic signed [DW-1:0] sa_w, sb_w, ps_w;
  logic        [DW-1:0] ua_w, ub_w, pu_w;
  logic signed [W-1:0]  sa_h, sb_h, ps_h;
  logic        [W-1:0]  ua_h, ub_h, pu_h;

  always_comb begin
    sa_w = {{W{a_i[W-1]}}, a_i};
    sb_w = {{W{b_i[W-1]}}, b_i};
    ua_w = {{W{1'b0}}, a_i};
    ub_w = {{W{1'b0}}, b_i};
    ps_w = sa_w * sb_w;
    pu_w = ua_w * ub_w;
    sa_h = {{(W-H){a_i[H-1]}}, a_i[H-1:0]};
    sb_h = {{(W-H){b_i[H-1]}}, b_i[H-1:0]};
    ua_h = {{(W-H){1'b0}}, a_i[H-1:0]};
    ub_h = {{(W-H){1'b0}}, b_i[H-1:0]};
    ps_h = sa_h * sb_h;
    pu_h = ua_h * ub_h;
  end

  always_comb begin
    unique case (op_i)
      OP_MAC16, OP_MULS16: prod_o = {{W{ps_h[W-1]}}, ps_h};
      OP_MULU16:           prod_o = {{W{1'b0}}, pu_h};
      OP_MULU64:           prod_o = pu_w;
      default:             prod_o = ps_w;
    endcase
  end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
  parameter int W     = 32,
  parameter int SAT_W = 48
) (
  input  logic [2*W-1:0] acc_i,
  input  logic [2*W-1:0] prod_i,
  input  logic           sat_i,
  output logic [2*W-1:0] mac16_o,
  output logic [2*W-1:0] mac32_o
);
  localparam int DW = 2 * W;
  localparam logic signed [W+1:0] MAX16 = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] MIN16 = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [DW:0]  MAX48 = {{(DW+2-SAT_W){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic signed [DW:0]  MIN48 = {{(DW+2-SAT_W){1'b1}}, {(SAT_W-1){1'b0}}};
  localparam logic [W-1:0]        ONE_W = {{(W-1){1'b0}}, 1'b1};

  logic signed [W+1:0] sum16;
  logic signed [DW:0]  sum64;
  logic        [DW-1:0] wrap64;

  always_comb begin
    wrap64 = acc_i + prod_i;
    sum16  = $signed({{2{acc_i[W-1]}}, acc_i[W-1:0]}) +
             $signed({{2{prod_i[W-1]}}, prod_i[W-1:0]});
    sum64  = $signed({acc_i[DW-1], acc_i}) + $signed({prod_i[DW-1], prod_i});

    if (!sat_i)              mac16_o = wrap64;
    else if (sum16 > MAX16)  mac16_o = {ONE_W, 1'b0, {(W-1){1'b1}}};
    else if (sum16 < MIN16)  mac16_o = {ONE_W, 1'b1, {(W-1){1'b0}}};
    else                     mac16_o = {acc_i[DW-1:W], sum16[W-1:0]};

    if (!sat_i)              mac32_o = wrap64;
    else if (sum64 > MAX48)  mac32_o = MAX48[DW-1:0];
    else if (sum64 < MIN48)  mac32_o = MIN48[DW-1:0];
    else                     mac32_o = sum64[DW-1:0];
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W     = 32,
  parameter int H     = 16,
  parameter int SAT_W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic [3:0]   cmd_op_i,
  input  logic         sat_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] acc_hi_o,
  output logic [W-1:0] acc_lo_o,
  output logic         done_o
);
  localparam int DW = 2 * W;

  mac_op_e       op;
  logic [DW-1:0] acc_q, acc_d, prod, mac16, mac32;
  logic          done_q;

  assign op = mac_op_e'(cmd_op_i);

  mac_mult #(.W(W), .H(H)) u_mult (
    .op_i  (op),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .prod_o(prod)
  );

  mac_sat #(.W(W), .SAT_W(SAT_W)) u_sat (
    .acc_i  (acc_q),
    .prod_i (prod),
    .sat_i  (sat_i),
    .mac16_o(mac16),
    .mac32_o(mac32)
  );

  always_comb begin
    acc_d = acc_q;
    if (cmd_valid_i) begin
      case (op)
        OP_CLR:                        acc_d = '0;
        OP_MAC16:                      acc_d = mac16;
        OP_MAC32:                      acc_d = mac32;
        OP_MULS64, OP_MULU64:          acc_d = prod;
        OP_MUL32, OP_MULS16, OP_MULU16: acc_d = {acc_q[DW-1:W], prod[W-1:0]};
        OP_LDHI:                       acc_d = {opa_i, acc_q[W-1:0]};
        OP_LDLO:                       acc_d = {acc_q[DW-1:W], opa_i};
        default:                       acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      done_q <= cmd_valid_i;
    end
  end

  assign acc_hi_o = acc_q[DW-1:W];
  assign acc_lo_o = acc_q[W-1:0];
  assign done_o   = done_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cmd_valid_i,
  input logic [3:0]   cmd_op_i,
  input logic         sat_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] acc_hi_o,
  input logic [W-1:0] acc_lo_o,
  input logic         done_o
);
  localparam logic signed [W-1:0] HI_MAX48 = {{(W-15){1'b0}}, {15{1'b1}}};
  localparam logic signed [W-1:0] HI_MIN48 = {{(W-15){1'b1}}, {15{1'b0}}};

  always_comb begin
    if (!rst_ni) assert_reset_clear_R1: assert (acc_hi_o == '0 && acc_lo_o == '0 && !done_o);
  end

  assert_done_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o && $stable(acc_hi_o) && $stable(acc_lo_o));
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_CLR |=> acc_hi_o == '0 && acc_lo_o == '0);
  assert_load_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_LDHI |=> acc_hi_o == $past(opa_i) && $stable(acc_lo_o));
  assert_load_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_LDLO |=> acc_lo_o == $past(opa_i) && $stable(acc_hi_o));
  assert_sat16_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && sat_i && cmd_op_i == OP_MAC16 |=>
      $stable(acc_hi_o) || acc_hi_o == {{(W-1){1'b0}}, 1'b1});
  assert_sat48_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && sat_i && cmd_op_i == OP_MAC32 |=>
      $signed(acc_hi_o) <= HI_MAX48 && $signed(acc_hi_o) >= HI_MIN48);
  assert_low_only_keeps_hi_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (cmd_op_i == OP_MUL32 || cmd_op_i == OP_MULS16 || cmd_op_i == OP_MULU16)
      |=> $stable(acc_hi_o));
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .sat_i      (sat_i),
  .opa_i      (opa_i),
  .acc_hi_o   (acc_hi_o),
  .acc_lo_o   (acc_lo_o),
  .done_o     (done_o)
);

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_op_i = '0;
  logic        sat_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [31:0] acc_hi_o, acc_lo_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { logic [63:0] exp; string req; } item_t;
  item_t sb_q[$];
  logic [63:0] model_acc = '0;

  always #4 clk_i = ~clk_i;

  mac_unit u_mac_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .sat_i(sat_i), .opa_i(opa_i), .opb_i(opb_i), .acc_hi_o(acc_hi_o),
    .acc_lo_o(acc_lo_o), .done_o(done_o)
  );

  function automatic logic [63:0] ref_next(logic [63:0] acc, logic [3:0] op, logic s,
                                           logic [31:0] a, logic [31:0] b);
    longint p;
    longint s16;
    logic signed [64:0] s64;
    logic [63:0] r;
    r = acc;
    case (op)
      4'd0: r = '0;
      4'd1: begin
        p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        if (!s) r = acc + 64'(p);
        else begin
          s16 = longint'($signed(acc[31:0])) + p;
          if (s16 > 64'sh7FFFFFFF) r = 64'h00000001_7FFFFFFF;
          else if (s16 < -64'sh80000000) r = 64'h00000001_80000000;
          else r = {acc[63:32], 32'(s16)};
        end
      end
      4'd2: begin
        p = longint'($signed(a)) * longint'($signed(b));
        if (!s) r = acc + 64'(p);
        else begin
          s64 = $signed({acc[63], acc}) + $signed({p[63], 64'(p)});
          if (s64 > 65'sh0_00007FFF_FFFFFFFF) r = 64'h00007FFF_FFFFFFFF;
          else if (s64 < -65'sh0_00008000_00000000) r = 64'hFFFF8000_00000000;
          else r = s64[63:0];
        end
      end
      4'd3: r = 64'(longint'($signed(a)) * longint'($signed(b)));
      4'd4: r = {32'b0, a} * {32'b0, b};
      4'd5: r = {acc[63:32], 32'(a * b)};
      4'd6: r = {acc[63:32], 32'(longint'($signed(a[15:0])) * longint'($signed(b[15:0])))};
      4'd7: r = {acc[63:32], 32'({16'b0, a[15:0]} * {16'b0, b[15:0]})};
      4'd8: r = {a, acc[31:0]};
      4'd9: r = {acc[63:32], a};
      default: r = acc;
    endcase
    return r;
  endfunction

  task automatic send(input logic [3:0] op, input logic s, input logic [31:0] a,
                      input logic [31:0] b, input string req);
    item_t it;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; sat_i = s; opa_i = a; opb_i = b;
    model_acc = ref_next(model_acc, op, s, a, b);
    it.exp = model_acc; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
    end
  endtask

  // monitor: one expected item per done pulse
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        item_t it;
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R2: done_o with no pending command, actual %h_%h expected none",
                   acc_hi_o, acc_lo_o);
        end else begin
          it = sb_q.pop_front();
          if ({acc_hi_o, acc_lo_o} !== it.exp) begin
            errors++;
            $display("FAIL %s: actual %h_%h expected %h_%h", it.req, acc_hi_o, acc_lo_o,
                     it.exp[63:32], it.exp[31:0]);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (acc_hi_o !== '0 || acc_lo_o !== '0 || done_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual %h_%h done %b expected 0_0 done 0", acc_hi_o, acc_lo_o, done_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (acc_hi_o !== '0 || acc_lo_o !== '0 || done_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: after release actual %h_%h done %b expected 0_0 done 0",
               acc_hi_o, acc_lo_o, done_o);
    end

    // R4 loads, R3 clear
    send(4'd8, 0, 32'h12345678, 0, "R4");
    send(4'd9, 0, 32'h9ABCDEF0, 0, "R4");
    send(4'd0, 0, 0, 0, "R3");
    // R5 unsaturated 16x16 carries into high half
    send(4'd9, 0, 32'hFFFFFFFF, 0, "R4");
    send(4'd1, 0, 32'hAAAA0002, 32'h55550003, "R5");
    send(4'd1, 0, 32'h0000FFFF, 32'h00000005, "R5");
    // R6 / R7 around the 32-bit limits
    send(4'd8, 0, 32'h000000AA, 0, "R4");
    send(4'd9, 0, 32'h7FFFFFF0, 0, "R4");
    send(4'd1, 1, 32'h00000003, 32'h00000005, "R7");
    send(4'd9, 0, 32'h7FFFFFF0, 0, "R4");
    send(4'd1, 1, 32'h00000004, 32'h00000004, "R6");
    send(4'd8, 0, 32'h00000055, 0, "R4");
    send(4'd9, 0, 32'h80000010, 0, "R4");
    send(4'd1, 1, 32'h0000FFFC, 32'h00000004, "R7");
    send(4'd9, 0, 32'h80000010, 0, "R4");
    send(4'd1, 1, 32'h0000FFEF, 32'h00000001, "R6");
    // R8 unsaturated 32x32 wrap
    send(4'd8, 0, 32'hFFFFFFFF, 0, "R4");
    send(4'd9, 0, 32'hFFFFFFFF, 0, "R4");
    send(4'd2, 0, 32'h00010000, 32'h00010000, "R8");
    send(4'd2, 0, 32'h80000000, 32'h7FFFFFFF, "R8");
    // R9 around the 48-bit limits
    send(4'd8, 0, 32'h00007FFF, 0, "R4");
    send(4'd9, 0, 32'hFFFFFFF0, 0, "R4");
    send(4'd2, 1, 32'h00000003, 32'h00000005, "R9");
    send(4'd9, 0, 32'hFFFFFFF0, 0, "R4");
    send(4'd8, 0, 32'h00007FFF, 0, "R4");
    send(4'd2, 1, 32'h00000004, 32'h00000004, "R9");
    send(4'd8, 0, 32'hFFFF8000, 0, "R4");
    send(4'd9, 0, 32'h00000010, 0, "R4");
    send(4'd2, 1, 32'hFFFFFFFC, 32'h00000004, "R9");
    send(4'd9, 0, 32'h00000010, 0, "R4");
    send(4'd8, 0, 32'hFFFF8000, 0, "R4");
    send(4'd2, 1, 32'hFFFFFFEF, 32'h00000001, "R9");
    // R10 full multiplies
    send(4'd3, 0, 32'hFFFFFFFF, 32'h00000002, "R10");
    send(4'd4, 0, 32'hFFFFFFFF, 32'h00000002, "R10");
    // R11 low-word multiply
    send(4'd8, 0, 32'hCAFEF00D, 0, "R4");
    send(4'd5, 0, 32'h12345678, 32'h9ABCDEF1, "R11");
    // R12 16x16 into low half
    send(4'd6, 0, 32'h00018000, 32'h00000002, "R12");
    send(4'd7, 0, 32'h00018000, 32'h00000002, "R12");
    // R2 unknown code keeps accumulator, idle cycles keep it too
    send(4'd13, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2");
    idle(3);
    send(4'd9, 0, 32'h00000001, 0, "R2");

    // random back-to-back commands
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 9));
      send(op, 1'($urandom), $urandom, $urandom, "R2 random");
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(3);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending results actual %0d expected 0", sb_q.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule